// File: doc/BRIEF.md
# DMA Transfer Checksum Sniffer

The sniffer sits beside a multi-channel DMA engine and watches the data each transfer carries. One channel is picked through a control word. Every transfer from that channel can pass through the gate, and a passing transfer folds its data into a single 32-bit accumulator in the same clock cycle. The accumulator can compute CRC-32 or CRC-16-CCITT, each with normal or bit-reversed input. It can also compute a running parity bit or a 32-bit additive sum.

Software loads a seed through a data write port and reads the result from the accumulator output. A transfer carries a byte, a halfword or a word in the low lanes of the data bus. An optional byte reverse turns the item around before it is accumulated. The sniffer sees data after the channel's own byte swap, so turning on both swaps leaves the sniffer with the data as it was in memory.

Top module: `sniff_unit`

## Requirements
- R1: After synchronous reset, `acc_out` is 0 and the control word is 0, which means the sniffer is disabled.
- R2: The control word has these fields: enable at bit 0, selected channel at bits [4:1], mode at bits [8:5] and byte reverse at bit 9. A transfer is accumulated only when all of the following hold: `xfer_valid` is high, enable is set, `xfer_chan` equals the selected channel, and `xfer_sniff_en` is high. In every other case `acc_out` does not change.
- R3: When `seed_we` is high, `acc_out` takes `seed_data` on the next edge. A seed write wins over a transfer in the same cycle. `acc_out` always shows the accumulator.
- R4: `xfer_size` sets the data item. Code 0 is a byte in `xfer_data[7:0]`, code 1 is a halfword in `xfer_data[15:0]` and code 2 is a word. Code 3 is ignored. A transfer updates `acc_out` at the edge where it is presented.
- R5: Mode 0 runs CRC-32 with polynomial 0x04C11DB7. The most significant bit of the item goes in first, and there is no final inversion. From seed 0xFFFFFFFF, the ASCII bytes "123456789" give 0x0376E6E7.
- R6: Modes 1 and 3 run the same CRC as modes 0 and 2, but on the item with its bits reversed across the item width.
- R7: Mode 2 runs CRC-16-CCITT with polynomial 0x1021 on `acc_out[15:0]`, and bits [31:16] become 0. From seed 0xFFFF, "123456789" gives 0x29B1.
- R8: Mode 0xE sets `acc_out` to {31'b0, acc_out[0] XOR (parity of the item)}.
- R9: Mode 0xF adds the zero-extended item to the accumulator modulo 2^32.
- R10: Byte reverse has no effect on a byte. It swaps the two bytes of a halfword and reverses the four bytes of a word. It is applied before any bit reversal.
- R11: Mode codes 4 to 13 leave `acc_out` unchanged.
- R12: Writing zero to the control word stops all accumulation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 10 | Control word (enable, channel, mode, byte reverse) |
| seed_we | input | 1 | Accumulator seed write strobe |
| seed_data | input | 32 | Seed value |
| xfer_valid | input | 1 | One transfer is present this cycle |
| xfer_chan | input | 4 | Channel number of the transfer |
| xfer_size | input | 2 | Item size code |
| xfer_data | input | 32 | Transfer data, item in the low lanes |
| xfer_sniff_en | input | 1 | The channel's own sniff permission |
| acc_out | output | 32 | Current accumulator value |

## Verification
The bench builds the block with its default of twelve channels. This gives a 4-bit channel field and the 10-bit control word layout above, so channel 11 is the highest valid selection and all the field positions the bench writes are fixed. The known check strings for both CRCs are fed as bytes, halfwords and words, and also as byte-reversed words. This shows that each item size and the reverse path keep the bit order the CRCs expect. A model in the bench follows a mixed table through every mode.

// File: rtl/sniff_pkg.sv
package sniff_pkg;

    localparam int          ACC_W       = 32;
    localparam logic [31:0] POLY_CRC32  = 32'h04C1_1DB7;
    localparam logic [15:0] POLY_CRC16  = 16'h1021;

    localparam logic [3:0]  MD_CRC32    = 4'h0;
    localparam logic [3:0]  MD_CRC32_BR = 4'h1;
    localparam logic [3:0]  MD_CRC16    = 4'h2;
    localparam logic [3:0]  MD_CRC16_BR = 4'h3;
    localparam logic [3:0]  MD_PARITY   = 4'hE;
    localparam logic [3:0]  MD_SUM      = 4'hF;

    // One data item, right-aligned, with its width in bits.
    typedef struct packed {
        logic [ACC_W-1:0] bits;
        logic [5:0]       nbits;
    } item_t;

    function automatic logic [31:0] byte_rev(input logic [31:0] d, input logic [1:0] sz);
        case (sz)
            2'd1:    return {16'h0, d[7:0], d[15:8]};
            2'd2:    return {d[7:0], d[15:8], d[23:16], d[31:24]};
            default: return d;
        endcase
    endfunction

    function automatic logic [31:0] bit_rev_n(input logic [31:0] d, input logic [5:0] n);
        logic [31:0] r;
        for (int i = 0; i < 32; i++) r[i] = d[31-i];
        return r >> (6'd32 - n);
    endfunction

    // Shift n item bits, most significant first, through a 32-bit CRC register.
    function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [31:0] d,
                                             input logic [5:0] n, input logic [31:0] poly);
        logic [31:0] r;
        logic        fb;
        r = c;
        for (int i = 31; i >= 0; i--) begin
            if (i < int'(n)) begin
                fb = r[31] ^ d[i];
                r  = {r[30:0], 1'b0};
                if (fb) r = r ^ poly;
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/sniff_item_prep.sv
module sniff_item_prep
    import sniff_pkg::*;
(
    input  logic [31:0] data,
    input  logic [1:0]  size,
    input  logic        swap_bytes,
    input  logic        rev_bits,
    output item_t       item,
    output logic        size_ok
);
    logic [31:0] masked;
    logic [31:0] swapped;
    logic [5:0]  width;

    always_comb begin
        case (size)
            2'd0:    begin width = 6'd8;  masked = {24'h0, data[7:0]};  end
            2'd1:    begin width = 6'd16; masked = {16'h0, data[15:0]}; end
            default: begin width = 6'd32; masked = data;                end
        endcase
        size_ok    = (size != 2'd3);
        swapped    = swap_bytes ? byte_rev(masked, size) : masked;
        item.nbits = width;
        item.bits  = rev_bits ? bit_rev_n(swapped, width) : swapped;
    end
endmodule

// File: rtl/sniff_accum_next.sv
module sniff_accum_next
    import sniff_pkg::*;
(
    input  logic [31:0] acc,
    input  logic [3:0]  mode,
    input  item_t       item,
    output logic [31:0] acc_nxt
);
    logic [31:0] c16;

    always_comb begin
        c16 = crc_step({acc[15:0], 16'h0}, item.bits, item.nbits, {POLY_CRC16, 16'h0});
        case (mode)
            MD_CRC32, MD_CRC32_BR: acc_nxt = crc_step(acc, item.bits, item.nbits, POLY_CRC32);
            MD_CRC16, MD_CRC16_BR: acc_nxt = {16'h0, c16[31:16]};
            MD_PARITY:             acc_nxt = {31'h0, acc[0] ^ (^item.bits)};
            MD_SUM:                acc_nxt = acc + item.bits;
            default:               acc_nxt = acc;
        endcase
    end
endmodule

// File: rtl/sniff_unit.sv
module sniff_unit
    import sniff_pkg::*;
#(
    parameter int NUM_CH = 12,
    localparam int CH_W  = $clog2(NUM_CH),
    localparam int CTL_W = CH_W + 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ctl_we,
    input  logic [CTL_W-1:0] ctl_wdata,
    input  logic             seed_we,
    input  logic [31:0]      seed_data,
    input  logic             xfer_valid,
    input  logic [CH_W-1:0]  xfer_chan,
    input  logic [1:0]       xfer_size,
    input  logic [31:0]      xfer_data,
    input  logic             xfer_sniff_en,
    output logic [31:0]      acc_out
);
    localparam int MODE_LO = CH_W + 1;
    localparam int REV_BIT = CH_W + 5;

    logic            cfg_en;
    logic [CH_W-1:0] cfg_chan;
    logic [3:0]      cfg_mode;
    logic            cfg_rev;
    logic [31:0]     acc;
    logic [31:0]     acc_nxt;
    item_t           item;
    logic            size_ok;
    logic            hit;
    logic            rev_bits;

    assign rev_bits = (cfg_mode == MD_CRC32_BR) || (cfg_mode == MD_CRC16_BR);
    assign hit      = xfer_valid && cfg_en && xfer_sniff_en && (xfer_chan == cfg_chan) && size_ok;

    sniff_item_prep u_prep (
        .data       (xfer_data),
        .size       (xfer_size),
        .swap_bytes (cfg_rev),
        .rev_bits   (rev_bits),
        .item       (item),
        .size_ok    (size_ok)
    );

    sniff_accum_next u_next (
        .acc     (acc),
        .mode    (cfg_mode),
        .item    (item),
        .acc_nxt (acc_nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_en   <= 1'b0;
            cfg_chan <= '0;
            cfg_mode <= '0;
            cfg_rev  <= 1'b0;
            acc      <= '0;
        end else begin
            if (ctl_we) begin
                cfg_en   <= ctl_wdata[0];
                cfg_chan <= ctl_wdata[CH_W:1];
                cfg_mode <= ctl_wdata[MODE_LO+3:MODE_LO];
                cfg_rev  <= ctl_wdata[REV_BIT];
            end
            if (seed_we)  acc <= seed_data;
            else if (hit) acc <= acc_nxt;
        end
    end

    assign acc_out = acc;
endmodule

// File: rtl/sniff_unit_chk.sv
module sniff_unit_chk (
    input logic        clk,
    input logic        rst,
    input logic        seed_we,
    input logic [31:0] seed_data,
    input logic        xfer_valid,
    input logic        hit,
    input logic [3:0]  cfg_mode,
    input logic [31:0] acc_out
);
    // R1
    a_r1_reset_clear: assert property (@(posedge clk) rst |=> acc_out == 32'h0);

    // R3
    a_r3_seed_load: assert property (@(posedge clk) disable iff (rst)
        seed_we |=> acc_out == $past(seed_data));

    // R2
    a_r2_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (!xfer_valid && !seed_we) |=> $stable(acc_out));

    // R7
    a_r7_crc16_upper_zero: assert property (@(posedge clk) disable iff (rst)
        (hit && !seed_we && (cfg_mode == 4'h2 || cfg_mode == 4'h3)) |=> acc_out[31:16] == 16'h0);

    // R8
    a_r8_parity_one_bit: assert property (@(posedge clk) disable iff (rst)
        (hit && !seed_we && cfg_mode == 4'hE) |=> acc_out[31:1] == 31'h0);

    // R11
    a_r11_reserved_hold: assert property (@(posedge clk) disable iff (rst)
        (hit && !seed_we && cfg_mode > 4'h3 && cfg_mode < 4'hE) |=> $stable(acc_out));
endmodule

bind sniff_unit sniff_unit_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .seed_we    (seed_we),
    .seed_data  (seed_data),
    .xfer_valid (xfer_valid),
    .hit        (hit),
    .cfg_mode   (cfg_mode),
    .acc_out    (acc_out)
);

// File: tb/tb_sniff_unit.sv
`timescale 1ns/1ps
module tb_sniff_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ctl_we = 1'b0;
    logic [9:0]  ctl_wdata = '0;
    logic        seed_we = 1'b0;
    logic [31:0] seed_data = '0;
    logic        xfer_valid = 1'b0;
    logic [3:0]  xfer_chan = '0;
    logic [1:0]  xfer_size = '0;
    logic [31:0] xfer_data = '0;
    logic        xfer_sniff_en = 1'b0;
    logic [31:0] acc_out;

    int errors = 0;
    int checks = 0;
    logic done = 1'b0;
    logic [31:0] mdl;

    always #2 clk = ~clk;

    sniff_unit dut (
        .clk(clk), .rst(rst), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
        .seed_we(seed_we), .seed_data(seed_data), .xfer_valid(xfer_valid),
        .xfer_chan(xfer_chan), .xfer_size(xfer_size), .xfer_data(xfer_data),
        .xfer_sniff_en(xfer_sniff_en), .acc_out(acc_out)
    );

    // {mode, size, rev, data}
    localparam logic [38:0] TBL [14] = '{
        {4'h0, 2'd2, 1'b0, 32'hDEAD_BEEF},
        {4'h0, 2'd0, 1'b1, 32'hFFFF_FF5A},
        {4'h1, 2'd0, 1'b0, 32'h0000_0013},
        {4'h1, 2'd2, 1'b1, 32'h1234_5678},
        {4'h2, 2'd1, 1'b0, 32'hAAAA_C3E1},
        {4'h3, 2'd1, 1'b1, 32'h0000_8001},
        {4'h3, 2'd0, 1'b0, 32'h0000_00F0},
        {4'h2, 2'd2, 1'b0, 32'h0102_0304},
        {4'hE, 2'd2, 1'b0, 32'h8000_0001},
        {4'hE, 2'd0, 1'b0, 32'hFFFF_FF07},
        {4'hF, 2'd2, 1'b0, 32'h7000_0000},
        {4'hF, 2'd1, 1'b1, 32'h0012_3456},
        {4'hF, 2'd0, 1'b0, 32'hFFFF_FF80},
        {4'h0, 2'd1, 1'b1, 32'h0000_4D2A}
    };

    // Independent model: item extracted byte by byte, fed bit by bit.
    function automatic logic [31:0] ref_next(input logic [31:0] a, input logic [3:0] m,
                                             input logic [1:0] sz, input logic rv, input logic [31:0] d);
        logic [7:0]  b [4];
        logic [31:0] it;
        int          nb;
        int          nbits;
        logic        fb;
        logic [15:0] c;
        nb = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
        nbits = nb * 8;
        for (int k = 0; k < 4; k++) b[k] = d[8*k +: 8];
        it = '0;
        for (int k = 0; k < nb; k++)
            it = rv ? ((it << 8) | 32'(b[k])) : (it | (32'(b[k]) << (8*k)));
        if (m == 4'h1 || m == 4'h3) begin
            logic [31:0] t;
            t = '0;
            for (int k = 0; k < nbits; k++) t[nbits-1-k] = it[k];
            it = t;
        end
        case (m)
            4'h0, 4'h1: begin
                for (int k = nbits - 1; k >= 0; k--) begin
                    fb = a[31] ^ it[k];
                    a  = a << 1;
                    if (fb) a = a ^ 32'h04C11DB7;
                end
                return a;
            end
            4'h2, 4'h3: begin
                c = a[15:0];
                for (int k = nbits - 1; k >= 0; k--) begin
                    fb = c[15] ^ it[k];
                    c  = c << 1;
                    if (fb) c = c ^ 16'h1021;
                end
                return {16'h0, c};
            end
            4'hE: return {31'h0, a[0] ^ (^it)};
            4'hF: return a + it;
            default: return a;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] exp);
        checks++;
        if (acc_out !== exp) begin
            errors++;
            $display("FAIL %s: acc_out=%08h expected %08h", tag, acc_out, exp);
        end
    endtask

    task automatic wr_ctl(input logic en, input logic [3:0] ch, input logic [3:0] md, input logic rv);
        @(negedge clk);
        ctl_we = 1'b1; ctl_wdata = {rv, md, ch, en};
        @(negedge clk);
        ctl_we = 1'b0;
    endtask

    task automatic wr_seed(input logic [31:0] v);
        @(negedge clk);
        seed_we = 1'b1; seed_data = v;
        @(negedge clk);
        seed_we = 1'b0;
    endtask

    task automatic xfer(input logic [3:0] ch, input logic sn, input logic [1:0] sz, input logic [31:0] d);
        @(negedge clk);
        xfer_valid = 1'b1; xfer_chan = ch; xfer_sniff_en = sn; xfer_size = sz; xfer_data = d;
        @(negedge clk);
        xfer_valid = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: run did not finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk("R1 reset value", 32'h0);
        // Disabled after reset: transfer ignored (R1, R2)
        xfer(4'd0, 1'b1, 2'd2, 32'h1234_5678);
        chk("R1 disabled after reset", 32'h0);

        wr_seed(32'hCAFE_0001);
        chk("R3 seed load", 32'hCAFE_0001);

        // Table walk against the model (R5 R6 R7 R8 R9 R10)
        mdl = 32'h1357_9BDF;
        wr_seed(mdl);
        for (int i = 0; i < 14; i++) begin
            wr_ctl(1'b1, 4'd5, TBL[i][38:35], TBL[i][32]);
            xfer(4'd5, 1'b1, TBL[i][34:33], TBL[i][31:0]);
            mdl = ref_next(mdl, TBL[i][38:35], TBL[i][34:33], TBL[i][32], TBL[i][31:0]);
            chk($sformatf("R5/R6/R7/R8/R9/R10 table row %0d", i), mdl);
        end

        // CRC-32 check string as bytes (R5, R4)
        wr_ctl(1'b1, 4'd11, 4'h0, 1'b0);
        wr_seed(32'hFFFF_FFFF);
        for (int k = 0; k < 9; k++) xfer(4'd11, 1'b1, 2'd0, 32'hFFFF_FF31 + k);
        chk("R5 crc32 bytes", 32'h0376_E6E7);
        // as words plus tail byte (R4)
        wr_seed(32'hFFFF_FFFF);
        xfer(4'd11, 1'b1, 2'd2, 32'h3132_3334);
        xfer(4'd11, 1'b1, 2'd2, 32'h3536_3738);
        xfer(4'd11, 1'b1, 2'd0, 32'h0000_0039);
        chk("R4 crc32 words", 32'h0376_E6E7);
        // byte-reversed words (R10)
        wr_ctl(1'b1, 4'd11, 4'h0, 1'b1);
        wr_seed(32'hFFFF_FFFF);
        xfer(4'd11, 1'b1, 2'd2, 32'h3433_3231);
        xfer(4'd11, 1'b1, 2'd2, 32'h3837_3635);
        xfer(4'd11, 1'b1, 2'd0, 32'h0000_0039);
        chk("R10 crc32 reversed words", 32'h0376_E6E7);

        // CRC-16 check string as halfwords (R7, R4)
        wr_ctl(1'b1, 4'd2, 4'h2, 1'b0);
        wr_seed(32'hABCD_FFFF);
        xfer(4'd2, 1'b1, 2'd1, 32'hEEEE_3132);
        xfer(4'd2, 1'b1, 2'd1, 32'h0000_3334);
        xfer(4'd2, 1'b1, 2'd1, 32'h0000_3536);
        xfer(4'd2, 1'b1, 2'd1, 32'h0000_3738);
        xfer(4'd2, 1'b1, 2'd0, 32'h0000_0039);
        chk("R7 crc16 halfwords", 32'h0000_29B1);

        // Gating (R2)
        mdl = acc_out;
        xfer(4'd3, 1'b1, 2'd2, 32'h1111_2222);
        chk("R2 wrong channel ignored", mdl);
        xfer(4'd2, 1'b0, 2'd2, 32'h1111_2222);
        chk("R2 sniff bit clear ignored", mdl);
        xfer(4'd2, 1'b1, 2'd3, 32'h1111_2222);
        chk("R4 size code 3 ignored", mdl);

        // Parity (R8) and sum wrap (R9)
        wr_ctl(1'b1, 4'd2, 4'hE, 1'b0);
        wr_seed(32'h0000_0000);
        xfer(4'd2, 1'b1, 2'd0, 32'hFFFF_FF07);
        chk("R8 parity odd", 32'h0000_0001);
        wr_ctl(1'b1, 4'd2, 4'hF, 1'b0);
        wr_seed(32'hFFFF_FFFF);
        xfer(4'd2, 1'b1, 2'd0, 32'h0000_0002);
        chk("R9 sum wraps", 32'h0000_0001);

        // Reserved mode (R11)
        wr_ctl(1'b1, 4'd2, 4'h5, 1'b0);
        xfer(4'd2, 1'b1, 2'd2, 32'hFFFF_FFFF);
        chk("R11 reserved mode holds", 32'h0000_0001);

        // Seed wins over transfer in the same cycle (R3)
        wr_ctl(1'b1, 4'd2, 4'hF, 1'b0);
        @(negedge clk);
        seed_we = 1'b1; seed_data = 32'h0000_0100;
        xfer_valid = 1'b1; xfer_chan = 4'd2; xfer_sniff_en = 1'b1; xfer_size = 2'd2; xfer_data = 32'h5;
        @(negedge clk);
        seed_we = 1'b0; xfer_valid = 1'b0;
        chk("R3 seed wins over transfer", 32'h0000_0100);

        // Zero control write disables (R12)
        @(negedge clk);
        ctl_we = 1'b1; ctl_wdata = '0;
        @(negedge clk);
        ctl_we = 1'b0;
        xfer(4'd0, 1'b1, 2'd2, 32'h0000_0007);
        chk("R12 zero control disables", 32'h0000_0100);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule